// File: doc/BRIEF.md
# Load/Store Effective Address Generator with Base Writeback

This block computes the memory address for one load or store and, in the same step, the value that the base register should take afterwards. It starts from a base register value and an offset. The offset is either a zero-extended immediate taken from the instruction, or a second register value shifted left by a variable amount. The offset is added to or subtracted from the base.

An indexing-mode select chooses which value goes to the memory bus and which one is written back. In offset mode the bus receives the combined value and the base stays as it was. In pre-index mode the bus receives the combined value and the base is updated to that same value. In post-index mode the bus receives the untouched base and the base is updated to the combined value.

All results are registered and appear one clock after a valid request. The register file write and the memory access are done by the surrounding pipeline, driven by the write enable and address produced here.

Top module: `agu_addr_unit`

## Requirements
- R1: With `idx_mode` = 2'b00 (offset), `mem_addr` equals base combined with the offset, `base_next` equals the unmodified base, and `wb_en` is 0.
- R2: With `idx_mode` = 2'b01 (pre-index), `mem_addr` and `base_next` both equal base combined with the offset, and `wb_en` is 1.
- R3: With `idx_mode` = 2'b10 (post-index), `mem_addr` equals the unmodified base, `base_next` equals base combined with the offset, and `wb_en` is 1.
- R4: With `off_is_reg` = 0 the offset is `imm_val` zero-extended to the data width. `reg_off` and `shamt` have no effect on the result.
- R5: With `off_is_reg` = 1 the offset is `reg_off` shifted left logically by `shamt` (0 to DATA_W-1). Bits shifted past the top are discarded.
- R6: `sub_off` = 1 subtracts the offset from the base and `sub_off` = 0 adds it. Both wrap modulo 2^DATA_W.
- R7: The unused code `idx_mode` = 2'b11 behaves exactly like offset mode: no writeback, and the base is passed through unchanged.
- R8: A request taken with `in_valid` high at one rising edge sets `res_valid` at that edge, and its results are on `mem_addr`, `base_next` and `wb_en` until the next edge.
- R9: After an edge with `in_valid` low, `res_valid` and `wb_en` are 0 and `mem_addr` and `base_next` keep their previous values.
- R10: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| base_val | input | DATA_W | Current base register value |
| imm_val | input | IMM_W | Immediate offset from the instruction |
| reg_off | input | DATA_W | Offset register value |
| shamt | input | $clog2(DATA_W) | Left-shift amount for the register offset |
| off_is_reg | input | 1 | 1: shifted register offset, 0: immediate offset |
| sub_off | input | 1 | 1: subtract the offset, 0: add it |
| idx_mode | input | 2 | 00 offset, 01 pre-index, 10 post-index, 11 as offset |
| mem_addr | output | DATA_W | Address driven to memory |
| base_next | output | DATA_W | Value for the base register |
| wb_en | output | 1 | Base register write enable |
| res_valid | output | 1 | Result valid, one cycle after the request |

## Verification
The bench builds the unit with its defaults, DATA_W = 32 and IMM_W = 12. With these values a shift of 31 can move bit 0 into the sign position and drop every other bit. The largest immediate, 0xFFF, can be zero-extended. Sums and differences can wrap across the 32-bit boundary in both directions. Back-to-back requests in all four mode codes are mixed with idle gaps that carry changing operands, so any leakage of those operands into the held outputs or the write enable shows up on the ports.

// File: rtl/agu_pkg.sv
package agu_pkg;

  // Indexing modes; encoding is visible at the idx_mode port.
  typedef enum logic [1:0] {
    IDX_OFFSET = 2'b00,
    IDX_PRE    = 2'b01,
    IDX_POST   = 2'b10,
    IDX_RSVD   = 2'b11
  } idx_mode_e;

  // Decoded routing controls for the output selector.
  typedef struct packed {
    logic sum_to_bus;   // bus carries base combined with offset
    logic sum_to_base;  // base register receives the combined value
    logic write_back;   // base register write requested
  } route_ctl_t;

  function automatic route_ctl_t decode_route(input idx_mode_e mode);
    route_ctl_t rc;
    unique case (mode)
      IDX_PRE:  rc = '{sum_to_bus: 1'b1, sum_to_base: 1'b1, write_back: 1'b1};
      IDX_POST: rc = '{sum_to_bus: 1'b0, sum_to_base: 1'b1, write_back: 1'b1};
      default:  rc = '{sum_to_bus: 1'b1, sum_to_base: 1'b0, write_back: 1'b0};
    endcase
    return rc;
  endfunction

endpackage

// File: rtl/agu_offset_gen.sv
module agu_offset_gen #(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 12,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [IMM_W-1:0]   imm_val,
  input  logic [DATA_W-1:0]  reg_off,
  input  logic [SHAMT_W-1:0] shamt,
  input  logic               off_is_reg,
  output logic [DATA_W-1:0]  off_val
);

  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] reg_scaled;

  // Logical left shift; bits beyond the top are dropped.
  function automatic logic [DATA_W-1:0] scale_by_shift(
    input logic [DATA_W-1:0]  val,
    input logic [SHAMT_W-1:0] amt
  );
    return val << amt;
  endfunction

  generate
    if (IMM_W >= DATA_W) begin : g_imm_trunc
      assign imm_ext = imm_val[DATA_W-1:0];
    end else begin : g_imm_zext
      assign imm_ext = {{(DATA_W-IMM_W){1'b0}}, imm_val};
    end
  endgenerate

  assign reg_scaled = scale_by_shift(reg_off, shamt);
  assign off_val    = off_is_reg ? reg_scaled : imm_ext;

endmodule

// File: rtl/agu_adder.sv
module agu_adder #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] base_val,
  input  logic [DATA_W-1:0] off_val,
  input  logic              sub_off,
  output logic [DATA_W-1:0] sum_val
);

  // Add or subtract, wrapping modulo 2^DATA_W.
  function automatic logic [DATA_W-1:0] combine(
    input logic [DATA_W-1:0] b,
    input logic [DATA_W-1:0] o,
    input logic              neg
  );
    logic [DATA_W-1:0] o_eff;
    o_eff = neg ? ~o : o;
    return b + o_eff + {{(DATA_W-1){1'b0}}, neg};
  endfunction

  assign sum_val = combine(base_val, off_val, sub_off);

endmodule

// File: rtl/agu_mode_mux.sv
module agu_mode_mux
  import agu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] base_val,
  input  logic [DATA_W-1:0] sum_val,
  input  logic [1:0]        idx_mode,
  output logic [DATA_W-1:0] addr_sel,
  output logic [DATA_W-1:0] base_sel,
  output logic              wb_req
);

  route_ctl_t rc;

  assign rc       = decode_route(idx_mode_e'(idx_mode));
  assign addr_sel = rc.sum_to_bus  ? sum_val : base_val;
  assign base_sel = rc.sum_to_base ? sum_val : base_val;
  assign wb_req   = rc.write_back;

endmodule

// File: rtl/agu_addr_unit.sv
module agu_addr_unit
  import agu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 12,
  localparam int SHAMT_W = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  base_val,
  input  logic [IMM_W-1:0]   imm_val,
  input  logic [DATA_W-1:0]  reg_off,
  input  logic [SHAMT_W-1:0] shamt,
  input  logic               off_is_reg,
  input  logic               sub_off,
  input  logic [1:0]         idx_mode,
  output logic [DATA_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  base_next,
  output logic               wb_en,
  output logic               res_valid
);

  // Internal events, named for the assertions.
  logic [DATA_W-1:0] off_val;
  logic [DATA_W-1:0] sum_val;
  logic [DATA_W-1:0] addr_sel;
  logic [DATA_W-1:0] base_sel;
  logic              wb_req;
  logic              take_req;

  assign take_req = in_valid;

  agu_offset_gen #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W),
    .SHAMT_W(SHAMT_W)
  ) u_offset (
    .imm_val   (imm_val),
    .reg_off   (reg_off),
    .shamt     (shamt),
    .off_is_reg(off_is_reg),
    .off_val   (off_val)
  );

  agu_adder #(
    .DATA_W(DATA_W)
  ) u_adder (
    .base_val(base_val),
    .off_val (off_val),
    .sub_off (sub_off),
    .sum_val (sum_val)
  );

  agu_mode_mux #(
    .DATA_W(DATA_W)
  ) u_mux (
    .base_val(base_val),
    .sum_val (sum_val),
    .idx_mode(idx_mode),
    .addr_sel(addr_sel),
    .base_sel(base_sel),
    .wb_req  (wb_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr  <= '0;
      base_next <= '0;
      wb_en     <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= take_req;
      wb_en     <= take_req & wb_req;
      if (take_req) begin
        mem_addr  <= addr_sel;
        base_next <= base_sel;
      end
    end
  end

  // R9
  wb_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> res_valid);

  // R8
  one_cycle_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == $past(in_valid & rst_n));

  // R3
  post_bus_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(idx_mode) == IDX_POST) |-> (mem_addr == $past(base_val) && wb_en));

  // R1
  offset_keeps_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && ($past(idx_mode) == IDX_OFFSET || $past(idx_mode) == IDX_RSVD))
      |-> (base_next == $past(base_val) && !wb_en));

  // R2
  pre_same_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(idx_mode) == IDX_PRE) |-> (mem_addr == base_next && wb_en));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(mem_addr) && $stable(base_next)));

endmodule

// File: tb/agu_addr_unit_bench.sv
module agu_addr_unit_bench;

  localparam int DW = 32;
  localparam int IW = 12;
  localparam int SW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] base_val = '0;
  logic [IW-1:0] imm_val = '0;
  logic [DW-1:0] reg_off = '0;
  logic [SW-1:0] shamt = '0;
  logic          off_is_reg = 1'b0;
  logic          sub_off = 1'b0;
  logic [1:0]    idx_mode = 2'b00;
  logic [DW-1:0] mem_addr;
  logic [DW-1:0] base_next;
  logic          wb_en;
  logic          res_valid;

  always #10 clk = ~clk;  // 50 MHz

  agu_addr_unit u_agu_addr_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .base_val(base_val), .imm_val(imm_val), .reg_off(reg_off),
    .shamt(shamt), .off_is_reg(off_is_reg), .sub_off(sub_off),
    .idx_mode(idx_mode), .mem_addr(mem_addr), .base_next(base_next),
    .wb_en(wb_en), .res_valid(res_valid)
  );

  typedef struct {
    logic [DW-1:0] addr;
    logic [DW-1:0] nb;
    logic          wb;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  logic [DW-1:0] last_addr = '0;
  logic [DW-1:0] last_nb = '0;

  // Independent reference: 64-bit arithmetic, then truncate.
  function automatic exp_t model(
    input logic [DW-1:0] b, input logic [IW-1:0] im, input logic [DW-1:0] r,
    input logic [SW-1:0] sh, input logic isreg, input logic sb,
    input logic [1:0] md, input string tag);
    exp_t e;
    longint unsigned off, comb;
    if (isreg) begin
      off = longint'(r) * (64'd1 << sh);
      off = off & 64'hFFFF_FFFF;
    end else
      off = longint'(im);
    if (sb) comb = (64'h1_0000_0000 + longint'(b) - off) & 64'hFFFF_FFFF;
    else    comb = (longint'(b) + off) & 64'hFFFF_FFFF;
    e.tag = tag;
    case (md)
      2'b01:   begin e.addr = comb[DW-1:0]; e.nb = comb[DW-1:0]; e.wb = 1'b1; end
      2'b10:   begin e.addr = b;            e.nb = comb[DW-1:0]; e.wb = 1'b1; end
      default: begin e.addr = comb[DW-1:0]; e.nb = b;            e.wb = 1'b0; end
    endcase
    return e;
  endfunction

  task automatic issue(input logic [DW-1:0] b, input logic [IW-1:0] im,
                       input logic [DW-1:0] r, input logic [SW-1:0] sh,
                       input logic isreg, input logic sb, input logic [1:0] md,
                       input string tag);
    @(negedge clk);
    in_valid = 1'b1; base_val = b; imm_val = im; reg_off = r; shamt = sh;
    off_is_reg = isreg; sub_off = sb; idx_mode = md;
    exp_q.push_back(model(b, im, r, sh, isreg, sb, md, tag));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      base_val = base_val ^ 32'h5A5A_1234;
      imm_val = imm_val + 12'h111;
      reg_off = reg_off + 32'h0100_0001;
      shamt = shamt + 5'd3;
      idx_mode = 2'b01;
      sub_off = ~sub_off;
    end
  endtask

  // Monitor: compare results at the falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (res_valid) begin
        n_chk++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL R8: unexpected result addr=%h nb=%h expected no result", mem_addr, base_next);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (mem_addr !== e.addr || base_next !== e.nb || wb_en !== e.wb) begin
            n_bad++;
            $display("FAIL %s: addr=%h nb=%h wb=%b expected addr=%h nb=%h wb=%b",
                     e.tag, mem_addr, base_next, wb_en, e.addr, e.nb, e.wb);
          end
          last_addr = e.addr;
          last_nb = e.nb;
        end
      end else begin
        n_chk++;
        if (wb_en !== 1'b0 || mem_addr !== last_addr || base_next !== last_nb) begin
          n_bad++;
          $display("FAIL R9: idle wb=%b addr=%h nb=%h expected wb=0 addr=%h nb=%h",
                   wb_en, mem_addr, base_next, last_addr, last_nb);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    n_chk++;  // R10
    if (mem_addr !== '0 || base_next !== '0 || wb_en !== 1'b0 || res_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R10: reset outputs addr=%h nb=%h wb=%b v=%b expected all 0",
               mem_addr, base_next, wb_en, res_valid);
    end
    rst_n = 1'b1;
    idle(2);
    issue(32'h0000_1000, 12'h024, 32'h0, 5'd0, 1'b0, 1'b0, 2'b00, "R1");
    issue(32'h0000_2000, 12'h000, 32'h10, 5'd2, 1'b1, 1'b1, 2'b01, "R2");
    issue(32'h0000_3000, 12'h008, 32'h0, 5'd0, 1'b0, 1'b0, 2'b10, "R3");
    issue(32'h0000_0000, 12'hFFF, 32'hDEAD_BEEF, 5'd7, 1'b0, 1'b0, 2'b00, "R4");
    issue(32'h0000_0010, 12'h000, 32'h8000_0001, 5'd31, 1'b1, 1'b0, 2'b00, "R5");
    issue(32'h0000_0004, 12'h008, 32'h0, 5'd0, 1'b0, 1'b1, 2'b01, "R6");
    issue(32'hFFFF_FFF0, 12'h000, 32'h20, 5'd0, 1'b1, 1'b0, 2'b10, "R6");
    issue(32'h0000_5000, 12'h100, 32'h0, 5'd0, 1'b0, 1'b0, 2'b11, "R7");
    issue(32'h0000_6000, 12'h000, 32'h3, 5'd4, 1'b1, 1'b1, 2'b11, "R7");
    idle(3);
    for (int k = 0; k < 24; k++) begin
      issue(32'h1234_0000 * k + 32'h77, 12'(k * 12'h0A3), 32'h0F0F_0001 + k,
            5'(k * 7), k[0], k[1], k[3:2], "R8");
      if (k % 5 == 4) idle(2);
    end
    idle(4);
    if (exp_q.size() != 0) begin
      n_chk++;
      n_bad++;
      $display("FAIL R8: %0d results missing, expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule